// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Retire Unit

This block is the delivery stage for a single processor in an interrupt controller. Upstream gating logic has already decided that a source may interrupt this processor, and it presents a one-cycle raise request for that source. The block keeps two membership sets across the N sources. The pending set holds requests that are waiting for the processor. The in-service set holds interrupts that the processor has taken and not yet retired. The block also keeps one activity flag per source, a 4-bit task priority and an 8-bit spurious vector. From these it drives the processor's interrupt line.

The processor takes an interrupt with an acknowledge strobe. The vector it receives appears on `ack_vec` in the following cycle and stays there until the next acknowledge. The processor retires the most urgent in-service interrupt with an end-of-interrupt strobe. Because the two sets are separate, a pending interrupt is offered again after a retire only when its priority is above the highest priority still in service.

Each source's priority (5 bits), vector and sense type are live inputs owned by the source configuration logic. A source whose input level drops clears its activity flag through `act_clear`. The task priority and spurious vector registers are written from a shared data bus.

Top module: `cpu_intr_deliver`

## Requirements
- R1: A raise request for source i is accepted only when its priority is strictly greater than the task priority, compared as the 5-bit priority against the zero-extended 4-bit task priority. A request for a source already in the pending set is ignored. An ignored or rejected request changes neither `src_active` nor `cpu_irq`.
- R2: An accepted request puts the source in the pending set, and `src_active[i]` reads 1 from the next cycle. `cpu_irq` is 1 in the next cycle if the accepted priority exceeds the highest priority already pending (0 when the set is empty). Otherwise `cpu_irq` keeps its value.
- R3: The most urgent member of either set is the member with the highest nonzero priority. Among equal priorities the lowest source index wins.
- R4: An acknowledge with no pending member of nonzero priority returns the spurious vector. `ack_vec` changes only in the cycle after an acknowledge and holds its value otherwise.
- R5: If the chosen pending source has a clear activity flag, or its priority is no longer above the task priority, the block does three things. It clears the source's activity flag, returns the spurious vector, and removes the source from the pending set, so a later request for that source is accepted again.
- R6: Otherwise the acknowledge does three things. It returns the source's vector, moves the source from the pending set to the in-service set, and clears its activity flag only if the source is edge-sensitive (`src_level[i]`=0). A level-sensitive source (`src_level[i]`=1) keeps its activity flag.
- R7: An end-of-interrupt removes the most urgent in-service member. `cpu_irq` becomes 1 in the next cycle if the most urgent remaining pending source has a priority above the highest priority remaining in service (0 when that set is empty).
- R8: Reset sets `task_prio` to 0xF, `spur_vec` to 0xFF, `ack_vec` to 0xFF, `cpu_irq` to 0 and all sets and flags to empty. A task priority write stores `wdata[3:0]`, and a spurious vector write stores `wdata[7:0]`. Each is visible in the next cycle.
- R9: An acknowledge drops `cpu_irq` in the next cycle. A raise accepted in the same cycle that meets the R2 condition wins and keeps `cpu_irq` at 1. The acknowledge in that cycle chooses only among sources that were already pending.
- R10: `act_clear[i]` clears the activity flag of source i in the next cycle. An acceptance of source i in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_prio | input | NSRC*PW | Per-source priority, source i at bits [i*PW +: PW] |
| src_vec | input | NSRC*VW | Per-source vector, source i at bits [i*VW +: VW] |
| src_level | input | NSRC | 1 = level-sensitive, 0 = edge-sensitive |
| raise_req | input | NSRC | Raise request per source from the gating unit |
| act_clear | input | NSRC | Clear the activity flag of a source |
| ack_rd | input | 1 | Acknowledge strobe |
| eoi_we | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| spv_we | input | 1 | Spurious vector write strobe |
| wdata | input | VW | Write data for the two registers |
| cpu_irq | output | 1 | Interrupt line to the processor |
| ack_vec | output | VW | Vector returned by the last acknowledge |
| task_prio | output | TPW | Current task priority |
| spur_vec | output | VW | Current spurious vector |
| src_active | output | NSRC | Activity flag per source |

## Verification
The cycle where an acknowledge and a raise request coincide matters most. There the acknowledge must choose from the old pending set while the new source joins it, and the deassert from the acknowledge competes with the assert from the raise. The bench provokes this both with a raise whose priority exceeds the pending maximum and with one whose priority does not. In the first case `cpu_irq` must stay high. In the second it must fall. In both cases the returned vector must belong to the previously pending source, and a following acknowledge must return the newly raised one.

// File: rtl/cpu_intr_deliver.sv
module cpu_intr_deliver #(
  parameter int NSRC = 8,
  parameter int PW   = 5,
  parameter int TPW  = 4,
  parameter int VW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic [NSRC*VW-1:0] src_vec,
  input  logic [NSRC-1:0]    src_level,
  input  logic [NSRC-1:0]    raise_req,
  input  logic [NSRC-1:0]    act_clear,
  input  logic               ack_rd,
  input  logic               eoi_we,
  input  logic               tpr_we,
  input  logic               spv_we,
  input  logic [VW-1:0]      wdata,
  output logic               cpu_irq,
  output logic [VW-1:0]      ack_vec,
  output logic [TPW-1:0]     task_prio,
  output logic [VW-1:0]      spur_vec,
  output logic [NSRC-1:0]    src_active
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] pend_q, serv_q;
  logic [PW-1:0]   pr [NSRC];
  logic [VW-1:0]   vc [NSRC];
  logic [PW-1:0]   tpr_x;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign pr[g] = src_prio[g*PW +: PW];
    assign vc[g] = src_vec[g*VW +: VW];
  end
  assign tpr_x = PW'(task_prio);

  logic [PW-1:0]   p_best, s_best, pr_best, sr_best;
  logic [IW-1:0]   p_idx, s_idx;
  logic [NSRC-1:0] acc, ack_oh, eoi_oh;
  logic            raise_fire, ack_hit, ack_ok, eoi_fire;

  always_comb begin
    p_best = '0; p_idx = '0;
    s_best = '0; s_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && pr[i] > p_best) begin p_best = pr[i]; p_idx = IW'(i); end
      if (serv_q[i] && pr[i] > s_best) begin s_best = pr[i]; s_idx = IW'(i); end
    end
    acc = '0;
    raise_fire = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (raise_req[i] && !pend_q[i] && pr[i] > tpr_x) begin
        acc[i] = 1'b1;
        if (pr[i] > p_best) raise_fire = 1'b1;
      end
    end
    ack_hit = ack_rd && (p_best != '0);
    ack_oh  = ack_hit ? (NSRC'(1) << p_idx) : '0;
    ack_ok  = ack_hit && src_active[p_idx] && (p_best > tpr_x);
    eoi_oh  = (eoi_we && s_best != '0) ? (NSRC'(1) << s_idx) : '0;
    pr_best = '0;
    sr_best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && !ack_oh[i] && pr[i] > pr_best) pr_best = pr[i];
      if (serv_q[i] && !eoi_oh[i] && pr[i] > sr_best) sr_best = pr[i];
    end
    eoi_fire = eoi_we && (pr_best > sr_best);
  end

  logic [NSRC-1:0] act_n;
  always_comb begin
    act_n = src_active & ~act_clear;
    if (ack_hit && (!ack_ok || !src_level[p_idx])) act_n = act_n & ~ack_oh;
    act_n = act_n | acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      serv_q     <= '0;
      src_active <= '0;
      cpu_irq    <= 1'b0;
      ack_vec    <= '1;
      task_prio  <= '1;
      spur_vec   <= '1;
    end else begin
      pend_q     <= (pend_q & ~ack_oh) | acc;
      serv_q     <= (serv_q & ~eoi_oh) | (ack_ok ? ack_oh : '0);
      src_active <= act_n;
      cpu_irq    <= raise_fire | eoi_fire | (cpu_irq & ~ack_rd);
      if (ack_rd)  ack_vec   <= ack_ok ? vc[p_idx] : spur_vec;
      if (tpr_we)  task_prio <= wdata[TPW-1:0];
      if (spv_we)  spur_vec  <= wdata;
    end
  end
endmodule

// File: rtl/cpu_intr_deliver_chk.sv
module cpu_intr_deliver_chk #(
  parameter int NSRC = 8,
  parameter int PW   = 5,
  parameter int TPW  = 4,
  parameter int VW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC*PW-1:0] src_prio,
  input logic [NSRC-1:0]    raise_req,
  input logic [NSRC-1:0]    act_clear,
  input logic               ack_rd,
  input logic               eoi_we,
  input logic               tpr_we,
  input logic               spv_we,
  input logic [VW-1:0]      wdata,
  input logic               cpu_irq,
  input logic [VW-1:0]      ack_vec,
  input logic [TPW-1:0]     task_prio,
  input logic [VW-1:0]      spur_vec,
  input logic [NSRC-1:0]    src_active
);
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_irq && raise_req == '0 && !eoi_we) |=> !cpu_irq); // R2
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && raise_req == '0 && !eoi_we) |=> !cpu_irq); // R9
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd |=> $stable(ack_vec)); // R4
  AST_TPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> task_prio == $past(wdata[TPW-1:0])); // R8
  AST_SPV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    spv_we |=> spur_vec == $past(wdata)); // R8

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    AST_LOW_PRIO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_active[g] && src_prio[g*PW +: PW] <= PW'(task_prio)) |=> !src_active[g]); // R1
    AST_CLEAR_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (act_clear[g] && !raise_req[g]) |=> !src_active[g]); // R10
  end
endmodule

bind cpu_intr_deliver cpu_intr_deliver_chk #(.NSRC(NSRC), .PW(PW), .TPW(TPW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_prio(src_prio), .raise_req(raise_req),
  .act_clear(act_clear), .ack_rd(ack_rd), .eoi_we(eoi_we), .tpr_we(tpr_we),
  .spv_we(spv_we), .wdata(wdata), .cpu_irq(cpu_irq), .ack_vec(ack_vec),
  .task_prio(task_prio), .spur_vec(spur_vec), .src_active(src_active));

// File: tb/sim_cpu_intr_deliver.sv
module sim_cpu_intr_deliver;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8, PW = 5, TPW = 4, VW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC*PW-1:0] src_prio;
  logic [NSRC*VW-1:0] src_vec;
  logic [NSRC-1:0] src_level, raise_req, act_clear, src_active;
  logic ack_rd, eoi_we, tpr_we, spv_we, cpu_irq;
  logic [VW-1:0] wdata, ack_vec, spur_vec;
  logic [TPW-1:0] task_prio;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_intr_deliver #(.NSRC(NSRC), .PW(PW), .TPW(TPW), .VW(VW)) u0 (.*);

  // op: 0 raise, 1 ack, 2 eoi, 3 tpr write, 4 act clear, 5 raise+ack, 6 spv write
  // fields: op, arg, exp irq, exp vec, exp active, requirement
  localparam logic [35:0] TBL [0:33] = '{
    {3'd3, 12'h032, 1'b0, 8'hFF, 8'h00, 4'd8},  // R8
    {3'd0, 12'h002, 1'b1, 8'hFF, 8'h02, 4'd2},  // R2
    {3'd0, 12'h004, 1'b1, 8'hFF, 8'h06, 4'd2},  // R2
    {3'd0, 12'h002, 1'b1, 8'hFF, 8'h06, 4'd1},  // R1
    {3'd1, 12'h000, 1'b0, 8'h41, 8'h04, 4'd3},  // R3
    {3'd1, 12'h000, 1'b0, 8'h42, 8'h00, 4'd6},  // R6
    {3'd2, 12'h000, 1'b0, 8'h42, 8'h00, 4'd7},  // R7
    {3'd0, 12'h010, 1'b0, 8'h42, 8'h00, 4'd1},  // R1
    {3'd0, 12'h008, 1'b1, 8'h42, 8'h08, 4'd2},  // R2
    {3'd1, 12'h000, 1'b0, 8'h43, 8'h00, 4'd6},  // R6
    {3'd0, 12'h020, 1'b1, 8'h43, 8'h20, 4'd2},  // R2
    {3'd1, 12'h000, 1'b0, 8'h45, 8'h20, 4'd6},  // R6
    {3'd0, 12'h040, 1'b1, 8'h45, 8'h60, 4'd2},  // R2
    {3'd0, 12'h001, 1'b1, 8'h45, 8'h61, 4'd2},  // R2
    {3'd1, 12'h000, 1'b0, 8'h46, 8'h21, 4'd9},  // R9
    {3'd2, 12'h000, 1'b0, 8'h46, 8'h21, 4'd7},  // R7
    {3'd2, 12'h000, 1'b0, 8'h46, 8'h21, 4'd7},  // R7
    {3'd2, 12'h000, 1'b0, 8'h46, 8'h21, 4'd7},  // R7
    {3'd2, 12'h000, 1'b1, 8'h46, 8'h21, 4'd7},  // R7
    {3'd4, 12'h020, 1'b1, 8'h46, 8'h01, 4'd10}, // R10
    {3'd3, 12'h004, 1'b1, 8'h46, 8'h01, 4'd8},  // R8
    {3'd1, 12'h000, 1'b0, 8'hFF, 8'h00, 4'd5},  // R5
    {3'd0, 12'h001, 1'b0, 8'hFF, 8'h00, 4'd1},  // R1
    {3'd6, 12'h0A5, 1'b0, 8'hFF, 8'h00, 4'd8},  // R8
    {3'd1, 12'h000, 1'b0, 8'hA5, 8'h00, 4'd4},  // R4
    {3'd0, 12'h002, 1'b1, 8'hA5, 8'h02, 4'd2},  // R2
    {3'd4, 12'h002, 1'b1, 8'hA5, 8'h00, 4'd10}, // R10
    {3'd1, 12'h000, 1'b0, 8'hA5, 8'h00, 4'd5},  // R5
    {3'd0, 12'h002, 1'b1, 8'hA5, 8'h02, 4'd5},  // R5
    {3'd5, 12'h040, 1'b1, 8'h41, 8'h40, 4'd9},  // R9
    {3'd1, 12'h000, 1'b0, 8'h46, 8'h00, 4'd6},  // R6
    {3'd0, 12'h020, 1'b1, 8'h46, 8'h20, 4'd2},  // R2
    {3'd5, 12'h002, 1'b0, 8'h45, 8'h22, 4'd9},  // R9
    {3'd1, 12'h000, 1'b0, 8'h41, 8'h20, 4'd6}   // R6
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [11:0] arg);
    @(negedge clk);
    case (op)
      3'd0: raise_req = arg[7:0];
      3'd1: ack_rd = 1'b1;
      3'd2: eoi_we = 1'b1;
      3'd3: begin tpr_we = 1'b1; wdata = arg[7:0]; end
      3'd4: act_clear = arg[7:0];
      3'd5: begin raise_req = arg[7:0]; ack_rd = 1'b1; end
      default: begin spv_we = 1'b1; wdata = arg[7:0]; end
    endcase
    @(negedge clk);
    raise_req = '0; act_clear = '0; ack_rd = 0; eoi_we = 0; tpr_we = 0; spv_we = 0; wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // source priorities 3,5,5,9,2,7,12,1; vectors 0x40+i; source 5 level-sensitive
    src_prio = {5'd1, 5'd12, 5'd7, 5'd2, 5'd9, 5'd5, 5'd5, 5'd3};
    for (int i = 0; i < NSRC; i++) src_vec[i*VW +: VW] = 8'h40 + 8'(i);
    src_level = 8'h20;
    raise_req = '0; act_clear = '0; ack_rd = 0; eoi_we = 0; tpr_we = 0; spv_we = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(8, "reset task_prio", 32'(task_prio), 32'hF);   // R8
    check(8, "reset spur_vec", 32'(spur_vec), 32'hFF);
    check(8, "reset cpu_irq", 32'(cpu_irq), 32'h0);
    check(8, "reset ack_vec", 32'(ack_vec), 32'hFF);
    check(8, "reset src_active", 32'(src_active), 32'h0);
    do_op(3'd0, 12'h008);                                 // R1: prio 9 vs task 15
    check(1, "reject irq", 32'(cpu_irq), 32'h0);
    check(1, "reject active", 32'(src_active), 32'h0);
    do_op(3'd1, 12'h000);                                 // R4: empty set
    check(4, "empty ack vec", 32'(ack_vec), 32'hFF);

    for (int k = 0; k < 34; k++) begin
      do_op(TBL[k][35:33], TBL[k][32:21]);
      check(int'(TBL[k][3:0]), $sformatf("step %0d cpu_irq", k), 32'(cpu_irq), 32'(TBL[k][20]));
      check(int'(TBL[k][3:0]), $sformatf("step %0d ack_vec", k), 32'(ack_vec), 32'(TBL[k][19:12]));
      check(int'(TBL[k][3:0]), $sformatf("step %0d src_active", k), 32'(src_active), 32'(TBL[k][11:4]));
    end

    check(8, "final task_prio", 32'(task_prio), 32'h4);    // R8
    check(8, "final spur_vec", 32'(spur_vec), 32'hA5);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule